// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes waiting in an external holding register or FIFO into asynchronous serial frames on a single output line. When data is available it pulses a one-cycle read strobe and captures the byte into an internal shift register. It then waits for the far end to grant clear-to-send, emits a low start bit, and shifts out the data LSB first. An optional parity bit and one or two high stop bits follow.

Frame shape is picked at run time: 7 or 8 data bits, parity off or one of four kinds, and one or two stop bits. Timing advances only on a clock enable that pulses at sixteen times the baud rate, so the baud generator stays outside. Four one-hot status outputs show which phase the machine is in. When another byte is waiting at the end of the last stop bit, the machine loads it without passing through idle.

Top module: `uart_tx_engine`

## Requirements
- R1: While the synchronous active-high reset is asserted, idle status is high, the serial line is high and the read strobe stays low even if data is waiting.
- R2: A frame starts with one low bit, then the data bits LSB first. Each bit lasts exactly 16 pulses of the oversample enable, and clock cycles without the enable do not advance timing.
- R3: With the short-word control at 0 the frame carries 8 data bits. At 1 it carries 7 data bits, and bit 7 of the holding register has no effect on the frame.
- R4: With the two-stop control at 0 the frame ends with one high stop bit. At 1 it ends with two.
- R5: With parity enabled, one parity bit follows the data bits. Code 0 makes the count of ones over data and parity odd, code 1 makes it even, code 2 sends 0 and code 3 sends 1. In 7-bit mode only the 7 sent data bits count.
- R6: When the empty flag is low and the machine is idle or finishing its last stop bit, the read strobe is high for exactly one cycle. The byte present in that cycle is the one sent, whatever the holding register shows afterwards.
- R7: After a byte is taken, the line stays high in the start phase until clear-to-send (active high) is seen.
- R8: If the empty flag is low at the end of the last stop bit, the next byte is taken in that cycle and the machine goes straight to the start phase without idling.
- R9: Exactly one of the four status outputs (idle, start, shift, stop) is high at any time.
- R10: If the empty flag is high at the end of the last stop bit, the machine returns to idle with the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovs_en | input | 1 | Clock enable at 16x the baud rate |
| short_word | input | 1 | 0: 8 data bits, 1: 7 data bits |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| par_on | input | 1 | Parity bit enable |
| par_kind | input | 2 | 0 odd, 1 even, 2 space, 3 mark |
| cts | input | 1 | Clear to send, active high |
| hr_empty | input | 1 | Holding register empty flag |
| hr_data | input | 8 | Holding register byte |
| hr_rd | output | 1 | One-cycle read strobe to the holding register |
| txd | output | 1 | Serial output, idles high |
| st_idle | output | 1 | Idle phase status |
| st_start | output | 1 | Start phase status (clear-to-send wait and start bit) |
| st_shift | output | 1 | Data and parity phase status |
| st_stop | output | 1 | Stop phase status |

## Verification
If the oversample counter or bit counter were off, the line would change at the wrong sample point within one bit time. A frame-length mismatch would then show as idle status, or a missing read strobe, at the cycle where the frame should end. A wrong parity selection shows up in the single parity sample of each frame. The sweep covers every length, stop and parity combination over several data patterns, so such an error appears in the first frame that uses the faulty setting. A bad capture or a missed clear-to-send wait shows in the first data bit, or as a start bit sent while clear-to-send is low.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_SHIFT = 2'd2,
      ST_STOP  = 2'd3
   } tx_state_e;

   typedef enum logic [1:0] {
      PAR_ODD   = 2'd0,
      PAR_EVEN  = 2'd1,
      PAR_SPACE = 2'd2,
      PAR_MARK  = 2'd3
   } par_kind_e;
endpackage

// File: rtl/uart_tx_ovs.sv
module uart_tx_ovs #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   input  logic ovs_en,
   output logic bit_end
);
   localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;

   if (OVS < 2) begin : g_bad_ovs
      initial $fatal(1, "uart_tx_ovs: OVS must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign bit_end = ovs_en && (cnt == CW'(OVS - 1));

   always_ff @(posedge clk) begin
      if (rst || !run)
         cnt <= '0;
      else if (ovs_en)
         cnt <= bit_end ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  logic              short_word,
   input  logic              par_on,
   input  logic [1:0]        par_kind,
   output logic [DATA_W:0]   frame,
   output logic [$clog2(DATA_W+2)-1:0] nbits
);
   localparam int BW = $clog2(DATA_W + 2);

   logic [DATA_W-1:0] masked;
   logic              ones_odd;
   logic              pbit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      if (i == DATA_W - 1) begin : g_top
         assign masked[i] = data[i] & ~short_word;
      end else begin : g_low
         assign masked[i] = data[i];
      end
   end

   assign ones_odd = ^masked;

   always_comb begin
      case (par_kind_e'(par_kind))
         PAR_ODD:   pbit = ~ones_odd;
         PAR_EVEN:  pbit = ones_odd;
         PAR_SPACE: pbit = 1'b0;
         default:   pbit = 1'b1;
      endcase
      frame = {1'b1, masked};
      if (par_on) begin
         if (short_word) frame[DATA_W-1] = pbit;
         else            frame[DATA_W]   = pbit;
      end
   end

   assign nbits = BW'(DATA_W) - BW'(short_word) + BW'(par_on);
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ovs_en,
   input  logic              short_word,
   input  logic              two_stop,
   input  logic              par_on,
   input  logic [1:0]        par_kind,
   input  logic              cts,
   input  logic              hr_empty,
   input  logic [DATA_W-1:0] hr_data,
   output logic              hr_rd,
   output logic              txd,
   output logic              st_idle,
   output logic              st_start,
   output logic              st_shift,
   output logic              st_stop
);
   localparam int FW = DATA_W + 1;
   localparam int BW = $clog2(DATA_W + 2);

   if (DATA_W < 2) begin : g_bad_width
      initial $fatal(1, "uart_tx_engine: DATA_W must be at least 2");
   end

   tx_state_e     state;
   logic          start_go;
   logic [FW-1:0] sr;
   logic [BW-1:0] bits_left;
   logic          stop2_q;
   logic          stop_idx;

   logic [FW-1:0] frame_w;
   logic [BW-1:0] nbits_w;
   logic          bit_end;
   logic          run;
   logic          last_stop;
   logic          take;

   uart_tx_parity #(.DATA_W(DATA_W)) u_par (
      .data       (hr_data),
      .short_word (short_word),
      .par_on     (par_on),
      .par_kind   (par_kind),
      .frame      (frame_w),
      .nbits      (nbits_w)
   );

   assign run = (state == ST_START && start_go) || state == ST_SHIFT || state == ST_STOP;

   uart_tx_ovs #(.OVS(OVS)) u_ovs (
      .clk     (clk),
      .rst     (rst),
      .run     (run),
      .ovs_en  (ovs_en),
      .bit_end (bit_end)
   );

   assign last_stop = (state == ST_STOP) && bit_end && (stop_idx == stop2_q);
   assign take      = !rst && !hr_empty && (state == ST_IDLE || last_stop);
   assign hr_rd     = take;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         start_go  <= 1'b0;
         sr        <= '1;
         bits_left <= '0;
         stop2_q   <= 1'b0;
         stop_idx  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: ;
            ST_START: begin
               if (!start_go) begin
                  if (cts) start_go <= 1'b1;
               end else if (bit_end) begin
                  start_go <= 1'b0;
                  state    <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (bit_end) begin
                  sr        <= {1'b1, sr[FW-1:1]};
                  bits_left <= bits_left - 1'b1;
                  if (bits_left == BW'(1)) begin
                     state    <= ST_STOP;
                     stop_idx <= 1'b0;
                  end
               end
            end
            default: begin
               if (last_stop)    state    <= ST_IDLE;
               else if (bit_end) stop_idx <= 1'b1;
            end
         endcase
         if (take) begin
            sr        <= frame_w;
            bits_left <= nbits_w;
            stop2_q   <= two_stop;
            start_go  <= 1'b0;
            state     <= ST_START;
         end
      end
   end

   always_comb begin
      case (state)
         ST_IDLE:  txd = 1'b1;
         ST_START: txd = !start_go;
         ST_SHIFT: txd = sr[0];
         default:  txd = 1'b1;
      endcase
   end

   assign st_idle  = (state == ST_IDLE);
   assign st_start = (state == ST_START);
   assign st_shift = (state == ST_SHIFT);
   assign st_stop  = (state == ST_STOP);

   AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot({st_idle, st_start, st_shift, st_stop}))
      else $error("status not one-hot"); // R9
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst)
      hr_rd |=> !hr_rd)
      else $error("read strobe longer than one cycle"); // R6
   AST_RD_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
      hr_rd |-> !hr_empty)
      else $error("read strobe with empty holding register"); // R6
   AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
      st_idle |-> txd)
      else $error("line low while idle"); // R10
   AST_START_HIGH_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
      $rose(st_start) |-> txd)
      else $error("start bit before clear-to-send wait"); // R7
   AST_STOP_MARK: assert property (@(posedge clk) disable iff (rst)
      st_stop |-> txd)
      else $error("line low during stop phase"); // R4
   AST_STOP_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
      $rose(st_stop) |-> $past(st_shift))
      else $error("stop phase not entered from shift"); // R2
endmodule

// File: tb/uart_tx_engine_bench.sv
module uart_tx_engine_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ovs_en = 1'b0;
   logic       short_word = 1'b0;
   logic       two_stop = 1'b0;
   logic       par_on = 1'b0;
   logic [1:0] par_kind = 2'd0;
   logic       cts = 1'b1;
   logic       hr_empty = 1'b1;
   logic [7:0] hr_data = 8'h00;
   wire        hr_rd, txd, st_idle, st_start, st_shift, st_stop;

   int n_run  = 0;
   int n_fail = 0;
   int ce_per = 1;
   int ce_div = 0;
   bit done   = 1'b0;

   uart_tx_engine u_uart_tx_engine (
      .clk(clk), .rst(rst), .ovs_en(ovs_en), .short_word(short_word),
      .two_stop(two_stop), .par_on(par_on), .par_kind(par_kind), .cts(cts),
      .hr_empty(hr_empty), .hr_data(hr_data), .hr_rd(hr_rd), .txd(txd),
      .st_idle(st_idle), .st_start(st_start), .st_shift(st_shift), .st_stop(st_stop)
   );

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (ce_div >= ce_per - 1) begin
         ovs_en <= 1'b1;
         ce_div <= 0;
      end else begin
         ovs_en <= 1'b0;
         ce_div <= ce_div + 1;
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load(input logic [7:0] d);
      hr_data  = d;
      hr_empty = 1'b0;
      #1;
      chk("R6", "strobe when data waits in idle", {31'd0, hr_rd}, 32'd1);
      tick();
      chk("R6", "strobe drops after one cycle", {31'd0, hr_rd}, 32'd0);
      chk("R6", "start phase after take", {31'd0, st_start}, 32'd1);
      hr_empty = 1'b1;
      hr_data  = ~d;
   endtask

   task automatic rx_frame(input logic [7:0] d, input bit chain, input logic [7:0] nxt);
      logic eb [16];
      string tg [16];
      int n = 0;
      int nd;
      int ones = 0;
      logic pb;
      int cec = 0;
      int guard = 0;
      bit shape_bad = 1'b0;
      bit idle_seen = 1'b0;
      bit rd_bad = 1'b0;
      bit exp_rd;
      nd = short_word ? 7 : 8;
      eb[n] = 1'b0; tg[n] = "R2"; n = n + 1;
      for (int i = 0; i < nd; i++) begin
         eb[n] = d[i]; tg[n] = short_word ? "R3" : "R2"; n = n + 1;
         ones = ones + int'(d[i]);
      end
      if (par_on) begin
         case (par_kind)
            2'd0:    pb = (ones % 2 == 0);
            2'd1:    pb = (ones % 2 == 1);
            2'd2:    pb = 1'b0;
            default: pb = 1'b1;
         endcase
         eb[n] = pb; tg[n] = "R5"; n = n + 1;
      end
      eb[n] = 1'b1; tg[n] = "R4"; n = n + 1;
      if (two_stop) begin
         eb[n] = 1'b1; tg[n] = "R4"; n = n + 1;
      end
      while (txd !== 1'b0 && guard < 20000) begin
         tick();
         guard++;
      end
      chk("R2", "start bit appears", {31'd0, guard >= 20000}, 32'd0);
      forever begin
         if (ovs_en) cec++;
         exp_rd = chain && ovs_en && (cec == 16 * n);
         if (hr_rd !== exp_rd) rd_bad = 1'b1;
         if ($countones({st_idle, st_start, st_shift, st_stop}) != 1) shape_bad = 1'b1;
         if (st_idle) idle_seen = 1'b1;
         if (ovs_en && (cec % 16 == 8)) begin
            chk(tg[cec / 16], "line at mid-bit", {31'd0, txd}, {31'd0, eb[cec / 16]});
            if (chain && (cec / 16 == n - 1)) begin
               hr_data  = nxt;
               hr_empty = 1'b0;
            end
         end
         if (cec == 16 * n) break;
         tick();
      end
      chk("R9", "status one-hot through frame", {31'd0, shape_bad}, 32'd0);
      chk("R8", "no idle inside frame", {31'd0, idle_seen}, 32'd0);
      chk("R6", "strobe only at last stop end", {31'd0, rd_bad}, 32'd0);
      tick();
      if (chain) begin
         chk("R8", "straight to start phase", {31'd0, st_start}, 32'd1);
         chk("R6", "chained strobe one cycle", {31'd0, hr_rd}, 32'd0);
         hr_empty = 1'b1;
         hr_data  = ~nxt;
      end else begin
         chk("R10", "idle after frame", {31'd0, st_idle}, 32'd1);
         chk("R10", "line high after frame", {31'd0, txd}, 32'd1);
      end
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] pats [3];
      bit cts_bad;
      pats[0] = 8'hB4; pats[1] = 8'hFF; pats[2] = 8'h00;
      hr_empty = 1'b0;
      hr_data  = 8'h5A;
      repeat (3) tick();
      // R1: reset state with data waiting
      chk("R1", "idle status in reset", {31'd0, st_idle}, 32'd1);
      chk("R1", "line high in reset", {31'd0, txd}, 32'd1);
      chk("R1", "no strobe in reset", {31'd0, hr_rd}, 32'd0);
      chk("R9", "one-hot in reset", $countones({st_idle, st_start, st_shift, st_stop}), 32'd1);
      hr_empty = 1'b1;
      rst = 1'b0;
      tick();

      // Sweep all frame shapes
      for (int sw = 0; sw < 2; sw++)
         for (int ts = 0; ts < 2; ts++)
            for (int pk = 0; pk < 5; pk++)
               for (int p = 0; p < 3; p++) begin
                  short_word = sw[0];
                  two_stop   = ts[0];
                  par_on     = (pk != 4);
                  par_kind   = pk[1:0];
                  load(pats[p]);
                  rx_frame(pats[p], 1'b0, 8'h00);
               end

      // R3: bit 7 ignored in short mode, slow enable (R2 gating)
      ce_per = 3;
      short_word = 1'b1; two_stop = 1'b1; par_on = 1'b1; par_kind = 2'd1;
      load(8'h81);
      rx_frame(8'h81, 1'b0, 8'h00);
      load(8'h01);
      rx_frame(8'h01, 1'b0, 8'h00);

      // R7: clear-to-send wait
      ce_per = 2;
      short_word = 1'b0; two_stop = 1'b0; par_on = 1'b0;
      cts = 1'b0;
      load(8'hC6);
      cts_bad = 1'b0;
      for (int k = 0; k < 100; k++) begin
         if (txd !== 1'b1 || st_start !== 1'b1) cts_bad = 1'b1;
         tick();
      end
      chk("R7", "line held high without clear-to-send", {31'd0, cts_bad}, 32'd0);
      cts = 1'b1;
      rx_frame(8'hC6, 1'b0, 8'h00);

      // R8: back-to-back frames
      ce_per = 1;
      par_on = 1'b1; par_kind = 2'd0; two_stop = 1'b1;
      load(8'h3C);
      rx_frame(8'h3C, 1'b1, 8'hE1);
      rx_frame(8'hE1, 1'b0, 8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule